// File: doc/BRIEF.md
# Instruction Trace Exception Controller

This block decides, at the end of every instruction, whether the processor must take a trace exception. When it must, the block runs the whole entry sequence for it. A retire event arrives as a one-cycle `retire_valid` strobe. The strobe comes with four flags: change of flow, illegal, aborted and forced exception. It also carries the address of the next instruction. The trace mode is taken from two bits of the live status word `sr_in`. A forced exception is always served first. The trace comes second, and a pending interrupt is granted last.

A trace entry does the following, in order. It writes the status register back with supervisor level set and both trace bits cleared, while keeping its own copy of the old value. It then pushes a four-word frame onto the supervisor stack through a valid/ready word port, decrementing the stack pointer before each write. Last, it issues a single-cycle vector fetch request and waits for the fetch to be acknowledged.

The controller is a seven-state machine:
- IDLE accepts retires.
- FWAIT holds the forced-exception request until it is done.
- SAVE writes the status register.
- PUSH sends the frame.
- VREQ requests the vector.
- VWAIT waits for the acknowledge.
- FIN grants a pending interrupt.

The transitions are:
- IDLE→FWAIT when a forced exception retires.
- IDLE→SAVE when a trace hits.
- IDLE→FIN when only an interrupt is pending.
- FWAIT→SAVE or FWAIT→FIN on done.
- SAVE→PUSH.
- PUSH→VREQ on the last accepted word.
- VREQ→VWAIT.
- VWAIT→FIN on acknowledge.
- FIN→IDLE.

Top module: `trace_exc_ctrl`

## Requirements
- R1: The trace mode is status bits 15:14. The value 00 never traces and 10 traces every retire. The value 01 traces only a retire with `retire_cof` set. A trace hit enters SAVE one cycle after the retire is accepted.
- R2: Mode 11 never traces. A retire taken in mode 11 sets `rsv_mode` in the next cycle, and `rsv_mode` stays set until reset.
- R3: A retire flagged illegal never produces a trace entry.
- R4: An aborted retire produces no trace entry. A later normal retire of the same instruction is traced as usual.
- R5: A retire with `retire_forced` raises `fexc_req` from the next cycle until `fexc_done` is sampled. A pending trace enters SAVE in the cycle after that.
- R6: `irq_grant` pulses only in FIN, and only while `irq_level` is nonzero. FIN follows the end of any trace or forced sequence, or comes directly after a retire that takes no exception. It is never active while a frame, vector or forced request is in progress.
- R7: In SAVE, `sr_wr` is high for exactly one cycle. `sr_wdata` is then `sr_in` with bits 15 and 14 cleared and bit 13 (supervisor) set. The `sr_in` value in that cycle is the copy that gets pushed.
- R8: The frame words are next-PC bits 15:0, next-PC bits 31:16, 0x0024 and the saved status word, in that order. They go to `ssp_in`-2, -4, -6 and -8, with `ssp_in` sampled in SAVE. Each word is held stable until `stk_ready` is high.
- R9: The pushed PC equals the `retire_next_pc` of the accepted retire.
- R10: `vec_req` is high for exactly one cycle, in the cycle after the last word is accepted. In that cycle `vec_addr` is 0x00000024; in every other cycle `vec_addr` is 0.
- R11: `busy` is high from the cycle after an accepted exception-taking retire until FIN has ended. `retire_ready` is the inverse of `busy`, and a retire offered while busy is ignored.
- R12: After reset, the block is idle with `retire_ready` high. All request, write and flag outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| retire_valid | input | 1 | Instruction retire strobe |
| retire_ready | output | 1 | Retire can be accepted |
| retire_cof | input | 1 | Retired instruction changed flow |
| retire_illegal | input | 1 | Instruction was illegal or unimplemented |
| retire_abort | input | 1 | Instruction aborted by a bus or address error |
| retire_forced | input | 1 | Instruction forces its own exception |
| retire_next_pc | input | 32 | Address of the next instruction |
| irq_level | input | 3 | Pending interrupt level, 0 = none |
| sr_in | input | 16 | Current status register |
| sr_wr | output | 1 | Status register write strobe |
| sr_wdata | output | 16 | Status value to write |
| ssp_in | input | 32 | Current supervisor stack pointer |
| stk_valid | output | 1 | Stack word write valid |
| stk_ready | input | 1 | Stack word accepted |
| stk_addr | output | 32 | Stack word address |
| stk_data | output | 16 | Stack word data |
| fexc_req | output | 1 | Forced exception service request |
| fexc_done | input | 1 | Forced exception service finished |
| vec_req | output | 1 | Vector fetch request pulse |
| vec_addr | output | 32 | Vector fetch address |
| vec_ack | input | 1 | Vector fetch acknowledge |
| irq_grant | output | 1 | Interrupt may now be taken |
| busy | output | 1 | Exception sequence in progress |
| rsv_mode | output | 1 | Sticky reserved-mode flag |

## Verification
The bench drives inputs on the falling edge and samples outputs 5 ns later. Its behavioural model advances on the rising edge, so each result is compared in the cycle it is due, once every register on the way has been counted. A trace retire accepted at edge N gives `sr_wr` after edge N+1 and the first frame word after edge N+2. Each later word follows one edge after its predecessor was accepted. `vec_req` comes one edge after the last accepted word, and FIN one edge after the acknowledge. `rsv_mode` and `fexc_req` appear one edge after the retire. Scenario counts of status-write and grant pulses confirm which retires traced.

// File: rtl/trace_pkg.sv
package trace_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FWAIT,
        ST_SAVE,
        ST_PUSH,
        ST_VREQ,
        ST_VWAIT,
        ST_FIN
    } trc_state_t;

    typedef enum logic [1:0] {
        TM_OFF  = 2'b00,
        TM_FLOW = 2'b01,
        TM_ALL  = 2'b10,
        TM_RSVD = 2'b11
    } trc_mode_t;

    localparam int SR_T1_BIT = 15;
    localparam int SR_T0_BIT = 14;
    localparam int SR_S_BIT  = 13;

endpackage

// File: rtl/trace_decide.sv
module trace_decide
    import trace_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       accept,
    input  logic [1:0] mode_bits,
    input  logic       cof,
    input  logic       illegal,
    input  logic       abort,
    output logic       hit,
    output logic       rsv_flag
);

    trc_mode_t mode;
    logic      mode_hit;

    assign mode = trc_mode_t'(mode_bits);

    always_comb begin
        unique case (mode)
            TM_OFF:  mode_hit = 1'b0;
            TM_FLOW: mode_hit = cof;
            TM_ALL:  mode_hit = 1'b1;
            TM_RSVD: mode_hit = 1'b0;
        endcase
    end

    // not executed or not yet complete: no trace now
    assign hit = mode_hit && !illegal && !abort;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsv_flag <= 1'b0;
        end else if (accept && mode == TM_RSVD) begin
            rsv_flag <= 1'b1;
        end
    end

    // R2: reserved mode flag is sticky
    p_rsv_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsv_flag |=> rsv_flag);

    // R2: reserved mode retire raises the flag next cycle
    p_rsv_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && mode_bits == 2'b11) |=> rsv_flag);

endmodule

// File: rtl/trace_fsm.sv
module trace_fsm
    import trace_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic hit,
    input  logic forced,
    input  logic irq_pend,
    input  logic fexc_done,
    input  logic push_done,
    input  logic vec_ack,
    output logic busy,
    output logic fexc_req,
    output logic save,
    output logic vec_req,
    output logic irq_grant
);

    trc_state_t state, state_nx;
    logic       trace_pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            trace_pend <= 1'b0;
        end else begin
            state <= state_nx;
            if (accept) begin
                trace_pend <= hit;
            end
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    if (forced)        state_nx = ST_FWAIT;
                    else if (hit)      state_nx = ST_SAVE;
                    else if (irq_pend) state_nx = ST_FIN;
                end
            end
            ST_FWAIT: begin
                if (fexc_done) state_nx = trace_pend ? ST_SAVE : ST_FIN;
            end
            ST_SAVE:  state_nx = ST_PUSH;
            ST_PUSH: begin
                if (push_done) state_nx = ST_VREQ;
            end
            ST_VREQ:  state_nx = ST_VWAIT;
            ST_VWAIT: begin
                if (vec_ack) state_nx = ST_FIN;
            end
            ST_FIN:   state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        busy      = 1'b1;
        fexc_req  = 1'b0;
        save      = 1'b0;
        vec_req   = 1'b0;
        irq_grant = 1'b0;
        unique case (state)
            ST_IDLE:  busy      = 1'b0;
            ST_FWAIT: fexc_req  = 1'b1;
            ST_SAVE:  save      = 1'b1;
            ST_PUSH:  ;
            ST_VREQ:  vec_req   = 1'b1;
            ST_VWAIT: ;
            ST_FIN:   irq_grant = irq_pend;
            default:  busy      = 1'b1;
        endcase
    end

    // R11: an idle controller leaves idle only for an accepted retire
    p_idle_exit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !accept) |=> !busy);

    // R5: forced request persists until served
    p_fexc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fexc_req && !fexc_done) |=> fexc_req);

endmodule

// File: rtl/trace_frame.sv
module trace_frame #(
    parameter int AW      = 32,
    parameter int DW      = 16,
    parameter int VEC_NUM = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] sr_cap,
    input  logic [AW-1:0] ssp_cap,
    input  logic [AW-1:0] pc_cap,
    input  logic          stk_ready,
    output logic          stk_valid,
    output logic [AW-1:0] stk_addr,
    output logic [DW-1:0] stk_data,
    output logic          done
);

    localparam int            PCW  = AW / DW;
    localparam int            NW   = PCW + 2;
    localparam int            IW   = $clog2(NW);
    localparam logic [IW-1:0] LAST = IW'(NW - 1);
    localparam logic [AW-1:0] STEP = AW'(DW / 8);
    localparam logic [DW-1:0] VOFS = DW'(VEC_NUM * 4);

    logic          active;
    logic [IW-1:0] idx;
    logic [AW-1:0] sp;
    logic [DW-1:0] sr_q;
    logic [AW-1:0] pc_q;
    logic [DW-1:0] words [NW];

    for (genvar g = 0; g < PCW; g++) begin : g_pcw
        assign words[g] = pc_q[g*DW +: DW];
    end
    assign words[PCW]     = VOFS;
    assign words[PCW + 1] = sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active <= 1'b0;
            idx    <= '0;
            sp     <= '0;
            sr_q   <= '0;
            pc_q   <= '0;
        end else if (start) begin
            active <= 1'b1;
            idx    <= '0;
            sp     <= ssp_cap;
            sr_q   <= sr_cap;
            pc_q   <= pc_cap;
        end else if (active && stk_ready) begin
            sp  <= sp - STEP;
            idx <= idx + 1'b1;
            if (idx == LAST) begin
                active <= 1'b0;
            end
        end
    end

    assign stk_valid = active;
    assign stk_addr  = sp - STEP;
    assign stk_data  = words[idx];
    assign done      = active && stk_ready && (idx == LAST);

    // R8: a stalled word stays put
    p_stk_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_valid && !stk_ready) |=> (stk_valid && $stable(stk_addr) && $stable(stk_data)));

    // R8: each accepted word moves the address down one word
    p_addr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_valid && stk_ready && !done) |=> (stk_valid && stk_addr == $past(stk_addr) - STEP));

endmodule

// File: rtl/trace_exc_ctrl.sv
module trace_exc_ctrl
    import trace_pkg::*;
#(
    parameter int AW      = 32,
    parameter int DW      = 16,
    parameter int IRQW    = 3,
    parameter int VEC_NUM = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            retire_valid,
    output logic            retire_ready,
    input  logic            retire_cof,
    input  logic            retire_illegal,
    input  logic            retire_abort,
    input  logic            retire_forced,
    input  logic [AW-1:0]   retire_next_pc,
    input  logic [IRQW-1:0] irq_level,
    input  logic [DW-1:0]   sr_in,
    output logic            sr_wr,
    output logic [DW-1:0]   sr_wdata,
    input  logic [AW-1:0]   ssp_in,
    output logic            stk_valid,
    input  logic            stk_ready,
    output logic [AW-1:0]   stk_addr,
    output logic [DW-1:0]   stk_data,
    output logic            fexc_req,
    input  logic            fexc_done,
    output logic            vec_req,
    output logic [AW-1:0]   vec_addr,
    input  logic            vec_ack,
    output logic            irq_grant,
    output logic            busy,
    output logic            rsv_mode
);

    localparam logic [AW-1:0] VADDR = AW'(VEC_NUM * 4);

    logic          accept;
    logic          hit;
    logic          save;
    logic          push_done;
    logic          irq_pend;
    logic [AW-1:0] pc_hold;

    assign accept       = retire_valid && !busy;
    assign retire_ready = !busy;
    assign irq_pend     = |irq_level;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_hold <= '0;
        end else if (accept) begin
            pc_hold <= retire_next_pc;
        end
    end

    trace_decide u_decide (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .mode_bits ({sr_in[SR_T1_BIT], sr_in[SR_T0_BIT]}),
        .cof       (retire_cof),
        .illegal   (retire_illegal),
        .abort     (retire_abort),
        .hit       (hit),
        .rsv_flag  (rsv_mode)
    );

    trace_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .hit       (hit),
        .forced    (retire_forced),
        .irq_pend  (irq_pend),
        .fexc_done (fexc_done),
        .push_done (push_done),
        .vec_ack   (vec_ack),
        .busy      (busy),
        .fexc_req  (fexc_req),
        .save      (save),
        .vec_req   (vec_req),
        .irq_grant (irq_grant)
    );

    trace_frame #(
        .AW      (AW),
        .DW      (DW),
        .VEC_NUM (VEC_NUM)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (save),
        .sr_cap    (sr_in),
        .ssp_cap   (ssp_in),
        .pc_cap    (pc_hold),
        .stk_ready (stk_ready),
        .stk_valid (stk_valid),
        .stk_addr  (stk_addr),
        .stk_data  (stk_data),
        .done      (push_done)
    );

    always_comb begin
        sr_wdata            = sr_in;
        sr_wdata[SR_T1_BIT] = 1'b0;
        sr_wdata[SR_T0_BIT] = 1'b0;
        sr_wdata[SR_S_BIT]  = 1'b1;
    end

    assign sr_wr    = save;
    assign vec_addr = vec_req ? VADDR : '0;

    // R3: illegal instruction never enters the trace sequence
    p_illegal_no_trace_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && retire_illegal && !retire_forced) |=> !sr_wr);

    // R4: aborted instruction does not trace now
    p_abort_no_trace_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && retire_abort && !retire_forced) |=> !sr_wr);

    // R5: forced service never overlaps the trace entry
    p_fexc_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fexc_req |-> (!sr_wr && !stk_valid && !vec_req));

    // R6: interrupt grant never overlaps a trace sequence
    p_irq_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_grant |-> (!stk_valid && !vec_req && !fexc_req && !sr_wr));

    // R7: status write is a single pulse followed by the frame
    p_sr_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sr_wr |=> (!sr_wr && stk_valid));

    // R10: vector request lasts one cycle and follows the frame
    p_vec_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req |=> !vec_req);

    p_vec_after_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
        push_done |=> vec_req);

endmodule

// File: tb/trace_exc_ctrl_tb_top.sv
module trace_exc_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        retire_valid = 1'b0;
    logic        retire_ready;
    logic        retire_cof = 1'b0;
    logic        retire_illegal = 1'b0;
    logic        retire_abort = 1'b0;
    logic        retire_forced = 1'b0;
    logic [31:0] retire_next_pc = '0;
    logic [2:0]  irq_level = '0;
    logic [15:0] sr_in = '0;
    logic        sr_wr;
    logic [15:0] sr_wdata;
    logic [31:0] ssp_in = 32'h0000_4000;
    logic        stk_valid;
    logic        stk_ready = 1'b1;
    logic [31:0] stk_addr;
    logic [15:0] stk_data;
    logic        fexc_req;
    logic        fexc_done = 1'b0;
    logic        vec_req;
    logic [31:0] vec_addr;
    logic        vec_ack = 1'b0;
    logic        irq_grant;
    logic        busy;
    logic        rsv_mode;

    always #10 clk = ~clk;

    trace_exc_ctrl dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .retire_valid   (retire_valid),
        .retire_ready   (retire_ready),
        .retire_cof     (retire_cof),
        .retire_illegal (retire_illegal),
        .retire_abort   (retire_abort),
        .retire_forced  (retire_forced),
        .retire_next_pc (retire_next_pc),
        .irq_level      (irq_level),
        .sr_in          (sr_in),
        .sr_wr          (sr_wr),
        .sr_wdata       (sr_wdata),
        .ssp_in         (ssp_in),
        .stk_valid      (stk_valid),
        .stk_ready      (stk_ready),
        .stk_addr       (stk_addr),
        .stk_data       (stk_data),
        .fexc_req       (fexc_req),
        .fexc_done      (fexc_done),
        .vec_req        (vec_req),
        .vec_addr       (vec_addr),
        .vec_ack        (vec_ack),
        .irq_grant      (irq_grant),
        .busy           (busy),
        .rsv_mode       (rsv_mode)
    );

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    int n_sr_obs = 0;
    int n_irq_obs = 0;

    // behavioural reference: 0 idle, 1 forced wait, 2 save, 3 frame, 4 vector, 5 ack wait, 6 final
    int          m_st = 0;
    bit          m_tp = 0;
    bit          m_rsv = 0;
    logic [31:0] m_pc = '0;
    logic [31:0] q_addr[$];
    logic [15:0] q_data[$];

    bit          stall = 0;
    logic [7:0]  lfsr = 8'h5B;
    bit          fbusy = 0;
    int          fcnt = 0;
    bit          vbusy = 0;
    int          vcnt = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++;
            n_err++;
            $display("FAIL R11 watchdog: cycles=%0d expected below %0d", cyc, 100000);
            summary();
            $finish;
        end
    end

    // reference model, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_tp = 0; m_rsv = 0;
            q_addr.delete(); q_data.delete();
        end else begin
            case (m_st)
                0: if (retire_valid) begin
                    logic [1:0] md;
                    bit h;
                    md   = sr_in[15:14];
                    m_pc = retire_next_pc;
                    if (md == 2'b11) m_rsv = 1;
                    h = !retire_illegal && !retire_abort &&
                        (md == 2'b10 || (md == 2'b01 && retire_cof));
                    m_tp = h;
                    if (retire_forced) m_st = 1;
                    else if (h) m_st = 2;
                    else if (irq_level != 0) m_st = 6;
                end
                1: if (fexc_done) m_st = m_tp ? 2 : 6;
                2: begin
                    q_addr.push_back(ssp_in - 2); q_data.push_back(m_pc[15:0]);
                    q_addr.push_back(ssp_in - 4); q_data.push_back(m_pc[31:16]);
                    q_addr.push_back(ssp_in - 6); q_data.push_back(16'h0024);
                    q_addr.push_back(ssp_in - 8); q_data.push_back(sr_in);
                    m_st = 3;
                end
                3: if (stk_ready) begin
                    void'(q_addr.pop_front());
                    void'(q_data.pop_front());
                    if (q_addr.size() == 0) m_st = 4;
                end
                4: m_st = 5;
                5: if (vec_ack) m_st = 6;
                default: m_st = 0;
            endcase
        end
    end

    // per-cycle comparison, 5 ns after the falling edge
    always begin
        @(negedge clk);
        #5;
        if (rst_n) begin
            chk("R11 busy", busy, m_st != 0);
            chk("R11 retire_ready", retire_ready, m_st == 0);
            chk("R5 fexc_req", fexc_req, m_st == 1);
            chk("R1 R3 R4 sr_wr trace entry", sr_wr, m_st == 2);
            if (m_st == 2)
                chk("R7 sr_wdata", sr_wdata, (sr_in & 16'h3FFF) | 16'h2000);
            chk("R8 stk_valid", stk_valid, m_st == 3);
            if (m_st == 3 && q_addr.size() > 0) begin
                chk("R8 stk_addr", stk_addr, q_addr[0]);
                chk("R8 R9 stk_data", stk_data, q_data[0]);
            end
            chk("R10 vec_req", vec_req, m_st == 4);
            chk("R10 vec_addr", vec_addr, (m_st == 4) ? 32'h24 : 32'h0);
            chk("R6 irq_grant", irq_grant, (m_st == 6) && (irq_level != 0));
            chk("R2 rsv_mode", rsv_mode, m_rsv);
            if (sr_wr) n_sr_obs++;
            if (irq_grant) n_irq_obs++;
        end
    end

    // responders for stack, forced service and vector fetch
    always @(negedge clk) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        stk_ready = stall ? lfsr[0] : 1'b1;
        if (fexc_done) begin
            fexc_done = 0; fbusy = 0;
        end else if (fbusy) begin
            if (fcnt == 0) fexc_done = 1; else fcnt--;
        end else if (fexc_req) begin
            fbusy = 1; fcnt = 2;
        end
        if (vec_ack) begin
            vec_ack = 0; vbusy = 0;
        end else if (vbusy) begin
            if (vcnt == 0) vec_ack = 1; else vcnt--;
        end else if (vec_req) begin
            vbusy = 1; vcnt = 1;
        end
    end

    task automatic do_retire(input logic [31:0] pc, input bit cof, input bit ill,
                             input bit ab, input bit frc);
        @(negedge clk);
        retire_valid   = 1; retire_next_pc = pc;
        retire_cof     = cof; retire_illegal = ill;
        retire_abort   = ab; retire_forced = frc;
        @(negedge clk);
        retire_valid   = 0; retire_cof = 0; retire_illegal = 0;
        retire_abort   = 0; retire_forced = 0;
    endtask

    task automatic wait_idle();
        repeat (2) @(negedge clk);
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic expect_since(input int base, input int now, input int exp, input string tag);
        chk(tag, now - base, exp);
    endtask

    initial begin
        int b;
        int bi;
        repeat (3) @(negedge clk);
        #5;
        // R12 reset state
        chk("R12 busy after reset", busy, 0);
        chk("R12 ready after reset", retire_ready, 1);
        chk("R12 stk_valid after reset", stk_valid, 0);
        chk("R12 vec_req after reset", vec_req, 0);
        chk("R12 sr_wr after reset", sr_wr, 0);
        chk("R12 fexc_req after reset", fexc_req, 0);
        chk("R12 irq_grant after reset", irq_grant, 0);
        chk("R12 rsv_mode after reset", rsv_mode, 0);
        @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // R1 every-instruction mode
        sr_in = 16'h8000; ssp_in = 32'h0000_4000;
        b = n_sr_obs;
        do_retire(32'h1000_2002, 0, 0, 0, 0); wait_idle();
        expect_since(b, n_sr_obs, 1, "R1 mode 10 traces plain retire");

        // R1 change-of-flow mode
        sr_in = 16'h4000;
        b = n_sr_obs;
        do_retire(32'h0000_0100, 0, 0, 0, 0); wait_idle();
        expect_since(b, n_sr_obs, 0, "R1 mode 01 skips sequential retire");
        b = n_sr_obs;
        do_retire(32'hABCD_0010, 1, 0, 0, 0); wait_idle();
        expect_since(b, n_sr_obs, 1, "R1 mode 01 traces branch");

        // R1 tracing off
        sr_in = 16'h0000;
        b = n_sr_obs;
        do_retire(32'h0000_0200, 1, 0, 0, 0); wait_idle();
        expect_since(b, n_sr_obs, 0, "R1 mode 00 never traces");

        // R2 reserved mode
        sr_in = 16'hC000;
        b = n_sr_obs;
        do_retire(32'h0000_0300, 1, 0, 0, 0); wait_idle();
        expect_since(b, n_sr_obs, 0, "R2 mode 11 never traces");
        chk("R2 rsv_mode set", rsv_mode, 1);
        sr_in = 16'h0000;
        do_retire(32'h0000_0304, 0, 0, 0, 0); wait_idle();
        chk("R2 rsv_mode sticky", rsv_mode, 1);

        // R3 illegal
        sr_in = 16'h8000;
        b = n_sr_obs;
        do_retire(32'h0000_0400, 0, 1, 0, 0); wait_idle();
        expect_since(b, n_sr_obs, 0, "R3 illegal not traced");

        // R4 aborted then resumed
        b = n_sr_obs;
        do_retire(32'h0000_0500, 0, 0, 1, 0); wait_idle();
        expect_since(b, n_sr_obs, 0, "R4 aborted not traced");
        b = n_sr_obs;
        do_retire(32'h0000_0500, 0, 0, 0, 0); wait_idle();
        expect_since(b, n_sr_obs, 1, "R4 resumed retire traced");

        // R5 R6 forced + trace + pending interrupt
        irq_level = 3'd3; sr_in = 16'h8704; ssp_in = 32'h0000_6000;
        b = n_sr_obs; bi = n_irq_obs;
        do_retire(32'h0000_0600, 0, 0, 0, 1); wait_idle();
        expect_since(b, n_sr_obs, 1, "R5 trace after forced exception");
        expect_since(bi, n_irq_obs, 1, "R6 interrupt granted after trace");

        // R6 interrupt only
        sr_in = 16'h0000;
        b = n_sr_obs; bi = n_irq_obs;
        do_retire(32'h0000_0700, 0, 0, 0, 0); wait_idle();
        expect_since(b, n_sr_obs, 0, "R6 no trace with tracing off");
        expect_since(bi, n_irq_obs, 1, "R6 interrupt granted directly");

        // R5 forced without trace, no interrupt
        irq_level = 3'd0;
        bi = n_irq_obs;
        do_retire(32'h0000_0800, 0, 0, 0, 1); wait_idle();
        expect_since(bi, n_irq_obs, 0, "R6 no grant without pending level");

        // R8 R9 stalled stack port
        stall = 1; sr_in = 16'h8715; ssp_in = 32'h0000_8002;
        b = n_sr_obs;
        do_retire(32'hFEDC_BA98, 0, 0, 0, 0); wait_idle();
        expect_since(b, n_sr_obs, 1, "R8 stalled frame trace");
        stall = 0;

        // R11 retire while busy is ignored
        sr_in = 16'h8000; ssp_in = 32'h0000_4000;
        b = n_sr_obs;
        do_retire(32'h0000_0900, 0, 0, 0, 0);
        @(negedge clk);
        retire_valid = 1; retire_next_pc = 32'hDEAD_BEEF;
        repeat (3) @(negedge clk);
        retire_valid = 0;
        wait_idle();
        expect_since(b, n_sr_obs, 1, "R11 busy retire ignored");

        repeat (4) @(negedge clk);
        summary();
        $finish;
    end

endmodule